// File: doc/BRIEF.md
# Receive Traffic Class Separator

This block sits on the receive side of a transaction-layer packet stream, between a hard protocol core and the user logic. Each incoming packet is classified from its first header doubleword and stored, beat by beat, in one of two packet buffers. One buffer takes only requests that expect a completion: memory reads, I/O reads and writes, and configuration reads and writes. The other takes everything else: memory writes, messages and completions. It also takes packets whose header cannot be decoded, which it marks with an error bit. Each buffer drains through its own ready/valid output, and an output only presents a packet once all of it has been stored.

The block drives two backpressure signals back to the core, and each has a known latency. The general ready output stops every kind of traffic, but the core may still deliver two more beats after it falls. The request mask stops only completion-seeking requests, but the core may still deliver up to ten more of them after it rises. Both thresholds reserve exactly that much room. A full or stalled request buffer raises only the mask, so posted writes and completions keep flowing past queued requests and the link cannot deadlock.

Top module: `rx_class_splitter`

## Requirements
- R1: A start-of-packet beat is decoded from in_data[31:29] (format) and in_data[28:24] (type). The packet goes to the np output if it is one of the following: a memory read (format 000 or 001, type 00000 or 00001); an I/O read (format 000, type 00010); an I/O write (format 010, type 00010); a configuration read (format 000, type 00100 or 00101); a configuration write (format 010, type 00100 or 00101).
- R2: The following go to the pc output with pc_err low: a memory write (format 010 or 011, type 00000 or 00001); a completion (format 000 or 010, type 01010 or 01011); a message (format 001 or 011, type 10xxx).
- R3: Any other format/type combination, including any format with bit 2 set, goes to the pc output with pc_err high on every beat of that packet.
- R4: Every beat leaves on its output with the same data, sop and eop it entered with. Packets leave in arrival order within each output, and every beat after a packet's last beat starts with sop.
- R5: An output's valid stays low until the end-of-packet beat of the packet at its head has been stored, even if the earlier beats arrived much sooner.
- R6: np_mask is high exactly while the free space of the np buffer is below (NP_LAG_REQS+1)*NP_MAX_BEATS beats. With the defaults that is 22 of 32, so the mask is low with 10 beats stored and high with 12.
- R7: in_ready is low exactly while the free space of the pc buffer is below RDY_LAG+1 beats. With the defaults that is 3 of 16, so in_ready is high with 13 beats stored and low with 14.
- R8: No beat is lost in these two cases: when RDY_LAG beats arrive after in_ready falls, and when NP_LAG_REQS requests of NP_MAX_BEATS beats arrive after np_mask rises.
- R9: Packets bound for pc are accepted and delivered, with in_ready high, while the np buffer is full and its output is stalled.
- R10: While an output's valid is high and its ready is low, valid stays high and sop, eop, data (and pc_err) hold their values.
- R11: During and after reset, with nothing received, np_valid and pc_valid are low, np_mask is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Incoming beat is valid |
| in_sop | input | 1 | Incoming beat is the first of a packet |
| in_eop | input | 1 | Incoming beat is the last of a packet |
| in_data | input | DATA_W | Incoming beat; bits 31:24 of a first beat carry format and type |
| in_ready | output | 1 | General backpressure to the core (RDY_LAG beats of latency) |
| np_mask | output | 1 | Halts completion-seeking requests (NP_LAG_REQS requests of latency) |
| np_valid | output | 1 | Request output has a beat of a complete packet |
| np_ready | input | 1 | Request consumer accepts the beat |
| np_sop | output | 1 | Request output beat is first of packet |
| np_eop | output | 1 | Request output beat is last of packet |
| np_data | output | DATA_W | Request output beat data |
| pc_valid | output | 1 | Posted/completion output has a beat of a complete packet |
| pc_ready | input | 1 | Posted/completion consumer accepts the beat |
| pc_sop | output | 1 | Posted/completion output beat is first of packet |
| pc_eop | output | 1 | Posted/completion output beat is last of packet |
| pc_err | output | 1 | Packet type could not be decoded |
| pc_data | output | DATA_W | Posted/completion output beat data |

## Verification
The bench puts each threshold on its boundary. If the request mask rose one request late, the ten trailing requests would overrun the request buffer. If in_ready fell a beat late, the two lag beats would overflow the posted buffer. Both cases show up as lost or corrupted beats when the buffers are drained. The bench fills the request buffer completely with its output stalled and then sends writes and completions, so a design that let the full buffer block the shared input would leave those packets undelivered. A packet sent with idle gaps between its beats catches a buffer that presents a packet before its last beat is stored. Undecodable multi-beat packets catch an error bit that is set only on the first beat, and the format codes next to valid ones catch decode slips between reads, writes and four-doubleword forms.

// File: rtl/rxs_pkg.sv
// Shared types and decode function for the receive traffic class separator.
// Assumes format in bits [7:5] and type in bits [4:0] of the header byte.
package rxs_pkg;

    typedef enum logic [3:0] {
        KIND_MEM_RD,
        KIND_MEM_WR,
        KIND_IO_RD,
        KIND_IO_WR,
        KIND_CFG_RD,
        KIND_CFG_WR,
        KIND_CPL,
        KIND_MSG,
        KIND_BAD
    } tlp_kind_e;

    // Map format/type onto a packet kind; anything unrecognised is KIND_BAD.
    function automatic tlp_kind_e decode_kind(input logic [2:0] fmt, input logic [4:0] typ);
        tlp_kind_e k;
        k = KIND_BAD;
        if (!fmt[2]) begin
            casez (typ)
                5'b0000?: k = fmt[1] ? KIND_MEM_WR : KIND_MEM_RD;
                5'b00010: if (!fmt[0]) k = fmt[1] ? KIND_IO_WR : KIND_IO_RD;
                5'b0010?: if (!fmt[0]) k = fmt[1] ? KIND_CFG_WR : KIND_CFG_RD;
                5'b0101?: if (!fmt[0]) k = KIND_CPL;
                5'b10???: if (fmt[0]) k = KIND_MSG;
                default:  k = KIND_BAD;
            endcase
        end
        return k;
    endfunction

    // True for the kinds that expect a completion from this side.
    function automatic logic needs_completion(input tlp_kind_e k);
        return (k == KIND_MEM_RD) || (k == KIND_IO_RD) || (k == KIND_IO_WR) ||
               (k == KIND_CFG_RD) || (k == KIND_CFG_WR);
    endfunction

endpackage

// File: rtl/rxs_route.sv
// Per-beat route selection. Decodes the header byte on a start-of-packet beat
// and holds that decision for the remaining beats of the same packet.
// Assumes the upstream stream is well framed (sop opens, eop closes a packet).
module rxs_route (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       beat_valid,
    input  logic       beat_sop,
    input  logic [7:0] hdr_byte,
    output logic       beat_np,
    output logic       beat_err
);
    import rxs_pkg::*;

    tlp_kind_e sop_kind;
    logic      sop_np;
    logic      sop_bad;
    logic      held_np;
    logic      held_err;

    // Classify the header byte of the current beat.
    always_comb begin
        sop_kind = decode_kind(hdr_byte[7:5], hdr_byte[4:0]);
        sop_np   = needs_completion(sop_kind);
        sop_bad  = (sop_kind == KIND_BAD);
    end

    // Remember the route of the packet in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_np  <= 1'b0;
            held_err <= 1'b0;
        end else if (beat_valid && beat_sop) begin
            held_np  <= sop_np;
            held_err <= sop_bad;
        end
    end

    // Start beats use the fresh decode, continuation beats the held one.
    always_comb begin
        beat_np  = beat_sop ? sop_np  : held_np;
        beat_err = beat_sop ? sop_bad : held_err;
    end

endmodule

// File: rtl/rxs_pkt_fifo.sv
// Packet buffer with per-beat framing. The read side is offered only while at
// least one complete packet is stored, so a consumer always sees whole packets.
// Assumes DEPTH is a power of two and that the writer never exceeds free space.
module rxs_pkt_fifo #(
    parameter int W     = 64,
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     wr_sop,
    input  logic                     wr_eop,
    input  logic [W-1:0]             wr_payload,
    output logic [$clog2(DEPTH):0]   free_cnt,
    output logic                     rd_valid,
    input  logic                     rd_ready,
    output logic                     rd_sop,
    output logic                     rd_eop,
    output logic [W-1:0]             rd_payload
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

    logic [W+1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [AW:0]   used;
    logic [AW:0]   pkt_cnt;
    logic          pop;
    logic          out_mid;

    assign pop = rd_valid && rd_ready;

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= {wr_eop, wr_sop, wr_payload};
    end

    // Pointers, occupancy and complete-packet count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            used    <= '0;
            pkt_cnt <= '0;
        end else begin
            if (wr_en) wr_ptr <= wr_ptr + 1'b1;
            if (pop)   rd_ptr <= rd_ptr + 1'b1;
            used    <= used + (AW+1)'(wr_en) - (AW+1)'(pop);
            pkt_cnt <= pkt_cnt + (AW+1)'(wr_en && wr_eop) - (AW+1)'(pop && rd_eop);
        end
    end

    // Track whether the read side is inside a packet.
    always_ff @(posedge clk) begin
        if (!rst_n)   out_mid <= 1'b0;
        else if (pop) out_mid <= !rd_eop;
    end

    // Head entry and status outputs.
    assign {rd_eop, rd_sop, rd_payload} = mem[rd_ptr];
    assign rd_valid = (pkt_cnt != '0);
    assign free_cnt = DEPTH_V - used;

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> used < DEPTH_V);

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable({rd_eop, rd_sop, rd_payload}));

    // R4
    sop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !out_mid |-> rd_sop);

endmodule

// File: rtl/rx_class_splitter.sv
// Receive traffic class separator. Routes completion-seeking requests into a
// dedicated buffer and all other packets into a second one. Drives a general
// ready and a request-only mask, each reserving room for its known latency.
// Assumes every request is at most NP_MAX_BEATS beats, every other packet fits
// in PC_DEPTH-RDY_LAG-1 beats, and the header byte sits in in_data[31:24].
module rx_class_splitter #(
    parameter int DATA_W       = 64,
    parameter int NP_DEPTH     = 32,
    parameter int PC_DEPTH     = 16,
    parameter int NP_MAX_BEATS = 2,
    parameter int NP_LAG_REQS  = 10,
    parameter int RDY_LAG      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              np_mask,
    output logic              np_valid,
    input  logic              np_ready,
    output logic              np_sop,
    output logic              np_eop,
    output logic [DATA_W-1:0] np_data,
    output logic              pc_valid,
    input  logic              pc_ready,
    output logic              pc_sop,
    output logic              pc_eop,
    output logic              pc_err,
    output logic [DATA_W-1:0] pc_data
);
    localparam int NP_AW      = $clog2(NP_DEPTH);
    localparam int PC_AW      = $clog2(PC_DEPTH);
    localparam int NP_RESERVE = (NP_LAG_REQS + 1) * NP_MAX_BEATS;
    localparam int PC_RESERVE = RDY_LAG + 1;
    localparam int NP_MIN_AT_MASK = NP_LAG_REQS * NP_MAX_BEATS + NP_MAX_BEATS - 1;
    localparam logic [NP_AW:0] NP_RESERVE_V  = (NP_AW+1)'(NP_RESERVE);
    localparam logic [NP_AW:0] NP_MIN_MASK_V = (NP_AW+1)'(NP_MIN_AT_MASK);
    localparam logic [PC_AW:0] PC_RESERVE_V  = (PC_AW+1)'(PC_RESERVE);
    localparam logic [PC_AW:0] PC_LAG_V      = (PC_AW+1)'(RDY_LAG);

    logic           beat_np;
    logic           beat_err;
    logic           np_wr;
    logic           pc_wr;
    logic [NP_AW:0] np_free;
    logic [PC_AW:0] pc_free;
    logic [DATA_W:0] pc_rd_payload;

    // Route decision for the beat on the input.
    rxs_route u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_valid (in_valid),
        .beat_sop   (in_sop),
        .hdr_byte   (in_data[31:24]),
        .beat_np    (beat_np),
        .beat_err   (beat_err)
    );

    // Steer every valid beat to exactly one buffer.
    always_comb begin
        np_wr = in_valid && beat_np;
        pc_wr = in_valid && !beat_np;
    end

    // Buffer for requests that expect a completion.
    rxs_pkt_fifo #(.W(DATA_W), .DEPTH(NP_DEPTH)) u_np_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (np_wr),
        .wr_sop     (in_sop),
        .wr_eop     (in_eop),
        .wr_payload (in_data),
        .free_cnt   (np_free),
        .rd_valid   (np_valid),
        .rd_ready   (np_ready),
        .rd_sop     (np_sop),
        .rd_eop     (np_eop),
        .rd_payload (np_data)
    );

    // Buffer for posted writes, messages, completions and undecodable packets.
    rxs_pkt_fifo #(.W(DATA_W+1), .DEPTH(PC_DEPTH)) u_pc_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (pc_wr),
        .wr_sop     (in_sop),
        .wr_eop     (in_eop),
        .wr_payload ({beat_err, in_data}),
        .free_cnt   (pc_free),
        .rd_valid   (pc_valid),
        .rd_ready   (pc_ready),
        .rd_sop     (pc_sop),
        .rd_eop     (pc_eop),
        .rd_payload (pc_rd_payload)
    );

    assign {pc_err, pc_data} = pc_rd_payload;

    // Backpressure from free space, each with room for its own latency.
    always_comb begin
        np_mask  = (np_free < NP_RESERVE_V);
        in_ready = !(pc_free < PC_RESERVE_V);
    end

    // R6
    mask_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(np_mask) |-> np_free >= NP_MIN_MASK_V);

    // R7
    ready_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_ready) |-> pc_free >= PC_LAG_V);

endmodule

// File: tb/rx_class_splitter_tb_top.sv
// Directed bench for the receive traffic class separator.
module rx_class_splitter_tb_top;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_ready, np_mask;
    logic          np_valid, np_sop, np_eop;
    logic          np_ready = 1'b0;
    logic [DW-1:0] np_data;
    logic          pc_valid, pc_sop, pc_eop, pc_err;
    logic          pc_ready = 1'b0;
    logic [DW-1:0] pc_data;

    int            n_chk = 0, n_fail = 0, cyc = 0;
    bit            done = 1'b0;
    logic [DW+2:0] np_q[$];
    logic [DW+2:0] pc_q[$];
    logic [DW+2:0] got;
    logic [31:0]   seq = '0;

    always #5 clk = ~clk;

    rx_class_splitter dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
        .in_ready(in_ready), .np_mask(np_mask),
        .np_valid(np_valid), .np_ready(np_ready), .np_sop(np_sop), .np_eop(np_eop), .np_data(np_data),
        .pc_valid(pc_valid), .pc_ready(pc_ready), .pc_sop(pc_sop), .pc_eop(pc_eop),
        .pc_err(pc_err), .pc_data(pc_data)
    );

    task automatic check(input bit ok, input string tag, input logic [DW+2:0] act, input logic [DW+2:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Output monitors compare every accepted beat with the expected queues.
    always @(posedge clk) begin
        if (rst_n && !done) begin
            if (np_valid && np_ready) begin
                got = {1'b0, np_eop, np_sop, np_data};
                if (np_q.size() == 0) check(1'b0, "R1/R4 unexpected np beat", got, '0);
                else begin
                    check(got == np_q[0], "R1/R4 np beat", got, np_q[0]);
                    void'(np_q.pop_front());
                end
            end
            if (pc_valid && pc_ready) begin
                got = {pc_err, pc_eop, pc_sop, pc_data};
                if (pc_q.size() == 0) check(1'b0, "R2/R3/R4 unexpected pc beat", got, '0);
                else begin
                    check(got == pc_q[0], "R2/R3/R4 pc beat", got, pc_q[0]);
                    void'(pc_q.pop_front());
                end
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
            $finish;
        end
    end

    // Drive one beat and record where it must come out.
    task automatic beat(input bit sop, input bit eop, input logic [7:0] hdr, input bit to_np, input bit err);
        logic [DW-1:0] d;
        seq++;
        d = sop ? {seq, hdr, 24'hA00000 ^ seq[23:0]} : {seq, 32'hD00D0000 ^ seq};
        @(negedge clk);
        in_valid = 1'b1; in_sop = sop; in_eop = eop; in_data = d;
        if (to_np) np_q.push_back({1'b0, eop, sop, d});
        else       pc_q.push_back({err, eop, sop, d});
    endtask

    task automatic send_pkt(input logic [7:0] hdr, input int nb, input bit to_np, input bit err);
        for (int b = 0; b < nb; b++) beat(b == 0, b == nb - 1, hdr, to_np, err);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        end
    endtask

    // R11: state after reset.
    task automatic t_reset();
        check(in_ready == 1'b1, "R11 in_ready after reset", in_ready, 1);
        check(np_mask == 1'b0, "R11 np_mask after reset", np_mask, 0);
        check(np_valid == 1'b0, "R11 np_valid after reset", np_valid, 0);
        check(pc_valid == 1'b0, "R11 pc_valid after reset", pc_valid, 0);
    endtask

    // R1 R2 R3: each kind lands on the right output with the right error bit.
    task automatic t_classify();
        np_ready = 1'b1; pc_ready = 1'b1;
        send_pkt(8'h00, 1, 1, 0);  // memory read, 3DW
        send_pkt(8'h20, 1, 1, 0);  // memory read, 4DW
        send_pkt(8'h01, 1, 1, 0);  // locked read
        send_pkt(8'h02, 1, 1, 0);  // I/O read
        idle(1);
        send_pkt(8'h42, 2, 1, 0);  // I/O write
        send_pkt(8'h04, 1, 1, 0);  // config read type 0
        send_pkt(8'h45, 2, 1, 0);  // config write type 1
        send_pkt(8'h40, 2, 0, 0);  // memory write 3DW
        send_pkt(8'h60, 3, 0, 0);  // memory write 4DW
        idle(2);
        send_pkt(8'h0A, 1, 0, 0);  // completion
        send_pkt(8'h4A, 2, 0, 0);  // completion with data
        send_pkt(8'h0B, 1, 0, 0);  // locked completion
        send_pkt(8'h30, 1, 0, 0);  // message
        send_pkt(8'h72, 2, 0, 0);  // message with data
        send_pkt(8'h1F, 3, 0, 1);  // R3 undefined type
        send_pkt(8'h80, 2, 0, 1);  // R3 format bit 2 set
        send_pkt(8'h22, 1, 0, 1);  // R3 I/O with 4DW form
        send_pkt(8'h10, 2, 0, 1);  // R3 message with 3DW no-data form
        send_pkt(8'h44, 1, 1, 0);  // config write right after bad packet
        idle(20);
        check(np_q.size() == 0, "R1 np packets all delivered", np_q.size(), 0);
        check(pc_q.size() == 0, "R2 pc packets all delivered", pc_q.size(), 0);
    endtask

    // R5: no output before the last beat of a packet is stored.
    task automatic t_whole();
        pc_ready = 1'b1;
        beat(1, 0, 8'h60, 0, 0);
        for (int i = 0; i < 3; i++) begin
            idle(1);
            check(pc_valid == 1'b0, "R5 pc_valid low mid-packet", pc_valid, 0);
        end
        beat(0, 0, 8'h60, 0, 0);
        idle(1);
        check(pc_valid == 1'b0, "R5 pc_valid low before eop", pc_valid, 0);
        pc_ready = 1'b0;
        beat(0, 1, 8'h60, 0, 0);
        idle(1);
        check(pc_valid == 1'b1, "R5 pc_valid after eop stored", pc_valid, 1);
        pc_ready = 1'b1;
        idle(6);
        check(pc_q.size() == 0, "R5 packet delivered", pc_q.size(), 0);
    endtask

    // R6 R8 R9: request mask threshold, lag absorption and bypass.
    task automatic t_mask();
        np_ready = 1'b0; pc_ready = 1'b1;
        for (int i = 0; i < 5; i++) send_pkt(8'h42, 2, 1, 0);
        idle(1);
        check(np_mask == 1'b0, "R6 mask low at 10 beats", np_mask, 0);
        send_pkt(8'h45, 2, 1, 0);
        idle(1);
        check(np_mask == 1'b1, "R6 mask high at 12 beats", np_mask, 1);
        for (int i = 0; i < 10; i++) send_pkt(8'h42, 2, 1, 0);  // R8 lagging requests
        idle(1);
        check(in_ready == 1'b1, "R9 in_ready high with np full", in_ready, 1);
        send_pkt(8'h40, 2, 0, 0);
        send_pkt(8'h4A, 3, 0, 0);
        send_pkt(8'h30, 1, 0, 0);
        idle(8);
        check(pc_q.size() == 0, "R9 posted bypassed full np buffer", pc_q.size(), 0);
        check(np_valid == 1'b1, "R10 np_valid held while stalled", np_valid, 1);
        np_ready = 1'b1;
        idle(40);
        check(np_q.size() == 0, "R8 all 32 request beats intact", np_q.size(), 0);
        check(np_mask == 1'b0, "R6 mask low after drain", np_mask, 0);
    endtask

    // R7 R8 R10: ready threshold, two lag beats, stable stalled output.
    task automatic t_ready();
        logic [DW-1:0] held;
        pc_ready = 1'b0;
        for (int i = 0; i < 13; i++) send_pkt(8'h40, 1, 0, 0);
        idle(1);
        check(in_ready == 1'b1, "R7 in_ready high at 13 beats", in_ready, 1);
        send_pkt(8'h0A, 1, 0, 0);
        idle(1);
        check(in_ready == 1'b0, "R7 in_ready low at 14 beats", in_ready, 0);
        send_pkt(8'h40, 1, 0, 0);  // R8 lag beats
        send_pkt(8'h1F, 1, 0, 1);
        idle(2);
        check(pc_valid == 1'b1, "R10 pc_valid while stalled", pc_valid, 1);
        held = pc_data;
        idle(3);
        check(pc_valid == 1'b1 && pc_data == held, "R10 pc output held", pc_data, held);
        pc_ready = 1'b1;
        idle(30);
        check(pc_q.size() == 0, "R8 all 16 pc beats intact", pc_q.size(), 0);
        check(in_ready == 1'b1, "R7 in_ready back high", in_ready, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_classify();
        t_whole();
        t_mask();
        t_ready();
        idle(2);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule